// File: doc/BRIEF.md
# Ternary Match Table with Priority Lookup

This block is a small ternary content-addressable table. Every slot keeps a data word and a mask word of equal width. A mask bit set to 1 turns the stored bit into a don't-care, so each stored bit acts as 0, 1 or X. A slot only takes part in a lookup while its valid bit is set.

All access goes through one command port, which takes at most one command per clock. A write stores either the data word or the mask word of a slot. Writes can be issued on every cycle with no upper bound, which is how the table is loaded. A read returns one word of a slot on the next cycle.

A search compares a key against all valid slots at once. One of several global mask registers, chosen by the command, limits the compare to the bits it has set. The search reports the lowest matching slot index, a hit flag and a flag for more than one match. It also saves the key as the comparand. A learn command copies that comparand into the lowest free slot, or reports that the table is full.

Top module: `tcam_engine`

## Requirements
- R1: After reset every slot is invalid, every global mask register is all ones, and all result outputs (strobes, flags, indices, read data) are zero.
- R2: A write (cmd_op 1) with cmd_sel_mask 0 stores the slot's data word and marks the slot valid. With cmd_sel_mask 1 it stores the slot's mask word and leaves the valid bit unchanged. A read (cmd_op 2) raises rd_valid on the next cycle, with the data word (cmd_sel_mask 0) or the mask word (cmd_sel_mask 1) on rd_data.
- R3: In a search (cmd_op 3, key on cmd_wdata) a slot matches when it is valid and every bit that is compared is equal. A bit whose slot mask bit is 1 matches any key bit.
- R4: A set-global-mask command (cmd_op 5) loads cmd_wdata into the register chosen by cmd_gsel. A search compares only the bits that are 1 in the register chosen by its own cmd_gsel, for every slot.
- R5: When one or more slots match, rsp_index holds the lowest matching slot index.
- R6: rsp_multi is 1 exactly when two or more slots match. It is never 1 without rsp_hit.
- R7: The search result appears on the cycle after the command, with rsp_valid high for that one cycle. rsp_hit, rsp_multi and rsp_index then hold their values until the next search.
- R8: A search with no match gives rsp_hit 0, rsp_multi 0 and rsp_index 0.
- R9: A learn (cmd_op 4) writes the key of the most recent search into the lowest-index invalid slot. That slot gets an all-zero mask and becomes valid. On the next cycle lrn_valid is 1, lrn_full is 0 and lrn_index holds the slot index.
- R10: A learn while every slot is valid writes nothing. On the next cycle it gives lrn_valid 1, lrn_full 1 and lrn_index 0.
- R11: A clear command (cmd_op 6) invalidates the addressed slot, and the slot no longer matches any key.
- R12: Write commands issued on consecutive cycles each take effect, with no limit on the length of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Opcode: 0 nop, 1 write, 2 read, 3 search, 4 learn, 5 set global mask, 6 clear |
| cmd_addr | input | 4 | Slot index for write, read and clear |
| cmd_sel_mask | input | 1 | Selects the mask word (1) or the data word (0) for write and read |
| cmd_gsel | input | 2 | Global mask register used by search and set-global-mask |
| cmd_wdata | input | 72 | Write data, search key or global mask value |
| rsp_valid | output | 1 | Search result strobe |
| rsp_hit | output | 1 | At least one slot matched |
| rsp_multi | output | 1 | Two or more slots matched |
| rsp_index | output | 4 | Lowest matching slot index |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 72 | Word read from a slot |
| lrn_valid | output | 1 | Learn result strobe |
| lrn_full | output | 1 | Learn found no free slot |
| lrn_index | output | 4 | Slot written by the learn |

## Verification
The hardest state to reach from the ports is a completely full table, followed by a learn that must change nothing. The bench fills every slot with back-to-back write bursts. It then issues a learn after a missing search and repeats the same search. The repeat must still miss, which shows that no slot was overwritten. Two further checks follow. A mask word is written to a slot that is still invalid, to show the slot stays out of lookups. A slot is then cleared and learned back, to show the free-slot search picks it.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_WRITE  = 3'd1,
        OP_READ   = 3'd2,
        OP_SEARCH = 3'd3,
        OP_LEARN  = 3'd4,
        OP_SETGM  = 3'd5,
        OP_CLEAR  = 3'd6
    } tcam_op_e;
endpackage

// File: rtl/tcam_match_row.sv
module tcam_match_row #(
    parameter int WIDTH = 72
) (
    input  logic             row_valid,
    input  logic [WIDTH-1:0] row_data,
    input  logic [WIDTH-1:0] row_dc,
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] gmask,
    output logic             hit
);
    logic [WIDTH-1:0] diff;

    always_comb begin
        diff = (row_data ^ key) & ~row_dc & gmask;
        hit  = row_valid & ~(|diff);
    end
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
    parameter int N = 16,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic [W-1:0] idx,
    output logic         any
);
    always_comb begin
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/tcam_engine.sv
module tcam_engine
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 72,
    parameter int GMASKS  = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int GSEL_W = (GMASKS > 1) ? $clog2(GMASKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_addr,
    input  logic              cmd_sel_mask,
    input  logic [GSEL_W-1:0] cmd_gsel,
    input  logic [WIDTH-1:0]  cmd_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_multi,
    output logic [IDX_W-1:0]  rsp_index,
    output logic              rd_valid,
    output logic [WIDTH-1:0]  rd_data,
    output logic              lrn_valid,
    output logic              lrn_full,
    output logic [IDX_W-1:0]  lrn_index
);
    typedef struct packed {
        logic [ENTRIES-1:0][WIDTH-1:0] data;
        logic [ENTRIES-1:0][WIDTH-1:0] dc;
        logic [ENTRIES-1:0]            valid;
        logic [GMASKS-1:0][WIDTH-1:0]  gmask;
        logic [WIDTH-1:0]              cmp;
        logic                          rsp_valid;
        logic                          rsp_hit;
        logic                          rsp_multi;
        logic [IDX_W-1:0]              rsp_index;
        logic                          rd_valid;
        logic [WIDTH-1:0]              rd_data;
        logic                          lrn_valid;
        logic                          lrn_full;
        logic [IDX_W-1:0]              lrn_index;
    } state_t;

    state_t st_d, st_q;

    logic [WIDTH-1:0]   sel_gmask;
    logic [ENTRIES-1:0] hits;
    logic [ENTRIES-1:0] free_slots;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   free_idx;
    logic               hit_any;
    logic               free_any;
    logic               hit_multi;

    assign sel_gmask  = st_q.gmask[cmd_gsel];
    assign free_slots = ~st_q.valid;
    assign hit_multi  = |(hits & (hits - ENTRIES'(1)));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_row
        tcam_match_row #(.WIDTH(WIDTH)) i_row (
            .row_valid (st_q.valid[g]),
            .row_data  (st_q.data[g]),
            .row_dc    (st_q.dc[g]),
            .key       (cmd_wdata),
            .gmask     (sel_gmask),
            .hit       (hits[g])
        );
    end

    tcam_prio_enc #(.N(ENTRIES)) i_hit_enc (
        .req (hits),
        .idx (hit_idx),
        .any (hit_any)
    );

    tcam_prio_enc #(.N(ENTRIES)) i_free_enc (
        .req (free_slots),
        .idx (free_idx),
        .any (free_any)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rd_valid  = 1'b0;
        st_d.lrn_valid = 1'b0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_WRITE: begin
                    if (cmd_sel_mask) begin
                        st_d.dc[cmd_addr] = cmd_wdata;
                    end else begin
                        st_d.data[cmd_addr]  = cmd_wdata;
                        st_d.valid[cmd_addr] = 1'b1;
                    end
                end
                OP_READ: begin
                    st_d.rd_valid = 1'b1;
                    st_d.rd_data  = cmd_sel_mask ? st_q.dc[cmd_addr]
                                                 : st_q.data[cmd_addr];
                end
                OP_SEARCH: begin
                    st_d.cmp       = cmd_wdata;
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_hit   = hit_any;
                    st_d.rsp_multi = hit_multi;
                    st_d.rsp_index = hit_any ? hit_idx : '0;
                end
                OP_LEARN: begin
                    st_d.lrn_valid = 1'b1;
                    st_d.lrn_full  = ~free_any;
                    st_d.lrn_index = free_any ? free_idx : '0;
                    if (free_any) begin
                        st_d.data[free_idx]  = st_q.cmp;
                        st_d.dc[free_idx]    = '0;
                        st_d.valid[free_idx] = 1'b1;
                    end
                end
                OP_SETGM: st_d.gmask[cmd_gsel] = cmd_wdata;
                OP_CLEAR: st_d.valid[cmd_addr] = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.gmask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_multi = st_q.rsp_multi;
    assign rsp_index = st_q.rsp_index;
    assign rd_valid  = st_q.rd_valid;
    assign rd_data   = st_q.rd_data;
    assign lrn_valid = st_q.lrn_valid;
    assign lrn_full  = st_q.lrn_full;
    assign lrn_index = st_q.lrn_index;
endmodule

// File: rtl/tcam_engine_chk.sv
module tcam_engine_chk
    import tcam_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_multi,
    input logic [IDX_W-1:0] rsp_index,
    input logic             rd_valid,
    input logic             lrn_valid,
    input logic             lrn_full,
    input logic [IDX_W-1:0] lrn_index
);
    // R7
    search_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SEARCH) |=> rsp_valid);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable({rsp_hit, rsp_multi, rsp_index}));

    // R6
    multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> rsp_hit);

    // R8
    miss_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_index == '0 && !rsp_multi));

    // R2
    read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_READ) |=> rd_valid);

    // R9
    learn_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_LEARN) |=> lrn_valid);

    // R10
    full_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lrn_full |-> lrn_index == '0);

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, rd_valid, lrn_valid}));
endmodule

bind tcam_engine tcam_engine_chk #(.IDX_W(IDX_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_multi (rsp_multi),
    .rsp_index (rsp_index),
    .rd_valid  (rd_valid),
    .lrn_valid (lrn_valid),
    .lrn_full  (lrn_full),
    .lrn_index (lrn_index)
);

// File: tb/test_tcam_engine.sv
`timescale 1ns/1ps
module test_tcam_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [3:0]  cmd_addr = '0;
    logic        cmd_sel_mask = 1'b0;
    logic [1:0]  cmd_gsel = '0;
    logic [71:0] cmd_wdata = '0;
    logic        rsp_valid, rsp_hit, rsp_multi, rd_valid, lrn_valid, lrn_full;
    logic [3:0]  rsp_index, lrn_index;
    logic [71:0] rd_data;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tcam_engine i_tcam_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_sel_mask(cmd_sel_mask), .cmd_gsel(cmd_gsel),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_multi(rsp_multi), .rsp_index(rsp_index), .rd_valid(rd_valid),
        .rd_data(rd_data), .lrn_valid(lrn_valid), .lrn_full(lrn_full),
        .lrn_index(lrn_index)
    );

    typedef struct packed {
        logic [71:0] key;
        logic [1:0]  gsel;
        logic        hit;
        logic        multi;
        logic [3:0]  idx;
    } vec_t;

    // search vectors against slots 0..3 and global masks 1 (ignore bits 11:8) and 2 (all zero)
    localparam vec_t VECS [9] = '{
        '{72'h11,  2'd0, 1'b1, 1'b0, 4'd0},
        '{72'h2A,  2'd0, 1'b1, 1'b0, 4'd1},
        '{72'h25,  2'd0, 1'b1, 1'b1, 4'd1},
        '{72'h300, 2'd0, 1'b1, 1'b0, 4'd3},
        '{72'h000, 2'd1, 1'b1, 1'b0, 4'd3},
        '{72'h311, 2'd1, 1'b1, 1'b0, 4'd0},
        '{72'h311, 2'd3, 1'b0, 1'b0, 4'd0},
        '{72'h5A5, 2'd2, 1'b1, 1'b1, 4'd0},
        '{72'h305, 2'd0, 1'b0, 1'b0, 4'd0}
    };

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge with the result visible
    task automatic send(input logic [2:0] op, input logic [3:0] addr, input logic sm,
                        input logic [1:0] gs, input logic [71:0] wd);
        cmd_valid    = 1'b1;
        cmd_op       = op;
        cmd_addr     = addr;
        cmd_sel_mask = sm;
        cmd_gsel     = gs;
        cmd_wdata    = wd;
        @(negedge clk);
        cmd_valid    = 1'b0;
    endtask

    task automatic search_chk(input string tag, input logic [71:0] key, input logic [1:0] gs,
                              input logic hit, input logic multi, input logic [3:0] idx);
        send(3'd3, 4'd0, 1'b0, gs, key);
        chk({tag, " rsp_valid"}, 72'(rsp_valid), 72'(1'b1));
        chk({tag, " rsp_hit"}, 72'(rsp_hit), 72'(hit));
        chk({tag, " rsp_multi"}, 72'(rsp_multi), 72'(multi));
        chk({tag, " rsp_index"}, 72'(rsp_index), 72'(idx));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        chk("R1 rsp_valid", 72'(rsp_valid), 72'(0));
        chk("R1 rd_valid", 72'(rd_valid), 72'(0));
        chk("R1 lrn_valid", 72'(lrn_valid), 72'(0));
        chk("R1 rsp_index", 72'(rsp_index), 72'(0));
        chk("R1 rd_data", rd_data, 72'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: no slot valid, so an all-zero key misses
        search_chk("R1 empty", 72'h0, 2'd0, 1'b0, 1'b0, 4'd0);

        // R12: back-to-back burst of writes for slots 0..3; R2 mask write to invalid slot 6
        send(3'd1, 4'd0, 1'b0, 2'd0, 72'h11);
        send(3'd1, 4'd0, 1'b1, 2'd0, 72'h0);
        send(3'd1, 4'd1, 1'b0, 2'd0, 72'h20);
        send(3'd1, 4'd1, 1'b1, 2'd0, 72'h0F);
        send(3'd1, 4'd2, 1'b0, 2'd0, 72'h25);
        send(3'd1, 4'd2, 1'b1, 2'd0, 72'h0);
        send(3'd1, 4'd3, 1'b0, 2'd0, 72'h300);
        send(3'd1, 4'd3, 1'b1, 2'd0, 72'h0);
        send(3'd1, 4'd6, 1'b1, 2'd0, {72{1'b1}});
        // R4: load global mask registers 1 and 2
        send(3'd5, 4'd0, 1'b0, 2'd1, ~72'hF00);
        send(3'd5, 4'd0, 1'b0, 2'd2, 72'h0);

        // R2: read back data and mask of slot 1
        send(3'd2, 4'd1, 1'b0, 2'd0, 72'h0);
        chk("R2 rd_valid", 72'(rd_valid), 72'(1));
        chk("R2 data word", rd_data, 72'h20);
        send(3'd2, 4'd1, 1'b1, 2'd0, 72'h0);
        chk("R2 mask word", rd_data, 72'h0F);

        // R3 R4 R5 R6 R8 R12 (and R2: masked invalid slot 6 never matches)
        foreach (VECS[i]) begin
            search_chk($sformatf("R3/R4/R5/R6/R8 vec%0d", i), VECS[i].key, VECS[i].gsel,
                       VECS[i].hit, VECS[i].multi, VECS[i].idx);
        end

        // R7: result holds after the strobe
        search_chk("R7 setup", 72'h300, 2'd0, 1'b1, 1'b0, 4'd3);
        send(3'd0, 4'd0, 1'b0, 2'd0, 72'h0);
        chk("R7 strobe low", 72'(rsp_valid), 72'(0));
        chk("R7 index held", 72'(rsp_index), 72'(3));
        chk("R7 hit held", 72'(rsp_hit), 72'(1));

        // R9: learn the last missing key into the lowest free slot (4)
        search_chk("R9 miss", 72'h305, 2'd0, 1'b0, 1'b0, 4'd0);
        send(3'd4, 4'd0, 1'b0, 2'd0, 72'h0);
        chk("R9 lrn_valid", 72'(lrn_valid), 72'(1));
        chk("R9 lrn_full", 72'(lrn_full), 72'(0));
        chk("R9 lrn_index", 72'(lrn_index), 72'(4));
        search_chk("R9 learned hit", 72'h305, 2'd0, 1'b1, 1'b0, 4'd4);

        // R12: long burst filling slots 5..15
        for (int s = 5; s < 16; s++) begin
            send(3'd1, 4'(s), 1'b0, 2'd0, 72'h1000 + 72'(s));
            send(3'd1, 4'(s), 1'b1, 2'd0, 72'h0);
        end
        search_chk("R12 burst slot 10", 72'h100A, 2'd0, 1'b1, 1'b0, 4'd10);
        search_chk("R12 burst slot 15", 72'h100F, 2'd0, 1'b1, 1'b0, 4'd15);

        // R10: learn on a full table writes nothing
        search_chk("R10 miss", 72'h7777, 2'd0, 1'b0, 1'b0, 4'd0);
        send(3'd4, 4'd0, 1'b0, 2'd0, 72'h0);
        chk("R10 lrn_valid", 72'(lrn_valid), 72'(1));
        chk("R10 lrn_full", 72'(lrn_full), 72'(1));
        chk("R10 lrn_index", 72'(lrn_index), 72'(0));
        search_chk("R10 still miss", 72'h7777, 2'd0, 1'b0, 1'b0, 4'd0);
        search_chk("R6 all match", 72'h0, 2'd2, 1'b1, 1'b1, 4'd0);

        // R11: clear slot 0, then learn refills it
        send(3'd6, 4'd0, 1'b0, 2'd0, 72'h0);
        search_chk("R11 cleared miss", 72'h11, 2'd0, 1'b0, 1'b0, 4'd0);
        send(3'd4, 4'd0, 1'b0, 2'd0, 72'h0);
        chk("R11 R9 relearn full", 72'(lrn_full), 72'(0));
        chk("R11 R9 relearn index", 72'(lrn_index), 72'(0));
        search_chk("R11 relearned hit", 72'h11, 2'd0, 1'b1, 1'b0, 4'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule